// File: doc/BRIEF.md
# Doorbell Mailbox over Shared Dual-Port Memory

This block is a message channel between a host processor and a motion-control processor. Each side has its own memory port with a one-cycle registered read. A word array behind the two ports is split into three areas: a message area the host sends through, a message area the device sends through, and a live status area. A small set of control addresses sits just above the array.

A sender first fills its message area and then writes its ring address with a sequence number. This marks the direction busy and raises the peer's interrupt line. The receiver answers by writing its acknowledge address with the same number. That write raises the sender's interrupt and, if the number matches, ends the busy state. While a direction is busy, the sender cannot overwrite its message area: such writes are dropped and counted. The status area can be written by either side at any time. Each interrupt is a level that stays up until its owner writes the clear address.

Top module: `mbox_top`

## Requirements
- R1: With default sizes, word addresses 0-15 are the host send area, 16-31 the device send area and 32-63 the status area. Control addresses are 64 (ring), 65 (acknowledge) and 66 (clear). A read with `*_en` high returns the addressed word on `*_rdata` after the next clock edge and holds it while `*_en` is low. A read of any address at or above 64 returns zero.
- R2: A side may write only its own send area and the status area. A write into the peer's send area leaves memory unchanged.
- R3: A ring write while its direction is idle sets that direction's busy flag. It stores `wdata[3:0]` as the pending sequence number and raises the peer's interrupt one cycle later.
- R4: A ring write while its direction is busy has no effect: busy, the pending number and the peer's interrupt are unchanged.
- R5: An acknowledge write raises the interrupt of the side whose message it acknowledges. If that direction is busy and `wdata[3:0]` equals the pending number, busy clears.
- R6: An acknowledge whose number differs from the pending one, or that arrives while the direction is idle, sets that direction's error flag and leaves busy unchanged.
- R7: A sender's write to its own send area while its direction is busy is dropped. It raises that direction's overrun count by one, and the count saturates at 255.
- R8: An interrupt line stays high until its own side writes the clear address. That clear also resets the error flag of the direction the side sends on. A new set in the same cycle as a clear wins.
- R9: When both ports write the same word in one cycle, the host value is stored and the sticky collision flag is set.
- R10: Status-area writes from either side take effect whatever the busy state of either direction.
- R11: After reset, all flags, counts, interrupts, read data and memory words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_en | input | 1 | Host port access enable |
| h_we | input | 1 | Host port write |
| h_addr | input | 7 | Host word address |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data |
| d_en | input | 1 | Device port access enable |
| d_we | input | 1 | Device port write |
| d_addr | input | 7 | Device word address |
| d_wdata | input | 32 | Device write data |
| d_rdata | output | 32 | Device read data |
| h_irq | output | 1 | Interrupt toward host |
| d_irq | output | 1 | Interrupt toward device |
| h2d_busy | output | 1 | Host-to-device message pending |
| d2h_busy | output | 1 | Device-to-host message pending |
| h2d_err | output | 1 | Bad acknowledge on host-to-device direction |
| d2h_err | output | 1 | Bad acknowledge on device-to-host direction |
| h2d_overrun | output | 8 | Dropped host send-area writes |
| d2h_overrun | output | 8 | Dropped device send-area writes |
| collision | output | 1 | Same-word write collision seen |

## Verification
On every cycle, the assertions tie each flag change to the port write that may cause it. Busy may rise only after a ring and fall only after an acknowledge. An interrupt may rise only after a ring or acknowledge from the peer and fall only after a clear. The overrun count may move only after a blocked send-area write, and control-address reads must return zero. These properties cannot show that the right value was stored, that a mismatched sequence number keeps busy set, that the host wins a collision, or that the count stops at 255. Those come from the bench's reference model, run under directed sequences and a long mixed random phase.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    typedef enum int {
        SIDE_HOST = 0,
        SIDE_DEV  = 1
    } side_e;

    localparam int REG_RING_OFS = 0;
    localparam int REG_ACK_OFS  = 1;
    localparam int REG_CLR_OFS  = 2;
endpackage

// File: rtl/mbox_ram.sv
module mbox_ram #(
    parameter int DW    = 32,
    parameter int WORDS = 64,
    localparam int RAW  = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          re_a,
    input  logic          we_a,
    input  logic [RAW-1:0] addr_a,
    input  logic [DW-1:0] wd_a,
    output logic [DW-1:0] rd_a,
    input  logic          re_b,
    input  logic          we_b,
    input  logic [RAW-1:0] addr_b,
    input  logic [DW-1:0] wd_b,
    output logic [DW-1:0] rd_b,
    output logic          clash
);
    logic [DW-1:0] mem_q [WORDS];

    assign clash = we_a && we_b && (addr_a == addr_b);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
            rd_a <= '0;
            rd_b <= '0;
        end else begin
            if (re_a) rd_a <= mem_q[addr_a];
            if (re_b) rd_b <= mem_q[addr_b];
            if (we_b && !clash) mem_q[addr_b] <= wd_b;
            if (we_a) mem_q[addr_a] <= wd_a;
        end
    end
endmodule

// File: rtl/mbox_chan.sv
module mbox_chan #(
    parameter int SEQ_W = 4,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_req,
    input  logic             ring_req,
    input  logic [SEQ_W-1:0] ring_seq,
    input  logic             ack_req,
    input  logic [SEQ_W-1:0] ack_seq,
    input  logic             clr_req,
    output logic             busy,
    output logic             err,
    output logic [CNT_W-1:0] overrun,
    output logic             tx_ok,
    output logic             ring_evt,
    output logic             ack_evt
);
    typedef struct packed {
        logic             busy;
        logic [SEQ_W-1:0] seq;
        logic             err;
        logic [CNT_W-1:0] ovr;
    } chan_t;

    chan_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        tx_ok    = tx_req && !st_q.busy;
        ring_evt = ring_req && !st_q.busy;
        ack_evt  = ack_req;
        if (tx_req && st_q.busy && (st_q.ovr != '1))
            st_d.ovr = st_q.ovr + 1'b1;
        if (clr_req)
            st_d.err = 1'b0;
        if (ring_evt) begin
            st_d.busy = 1'b1;
            st_d.seq  = ring_seq;
        end
        if (ack_req) begin
            if (st_q.busy && (ack_seq == st_q.seq)) st_d.busy = 1'b0;
            else                                    st_d.err  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy    = st_q.busy;
    assign err     = st_q.err;
    assign overrun = st_q.ovr;
endmodule

// File: rtl/mbox_top.sv
module mbox_top #(
    parameter int DW         = 32,
    parameter int MSG_WORDS  = 16,
    parameter int STAT_WORDS = 32,
    parameter int SEQ_W      = 4,
    parameter int CNT_W      = 8,
    localparam int RAM_WORDS = 2 * MSG_WORDS + STAT_WORDS,
    localparam int AW        = $clog2(RAM_WORDS) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             h_en,
    input  logic             h_we,
    input  logic [AW-1:0]    h_addr,
    input  logic [DW-1:0]    h_wdata,
    output logic [DW-1:0]    h_rdata,
    input  logic             d_en,
    input  logic             d_we,
    input  logic [AW-1:0]    d_addr,
    input  logic [DW-1:0]    d_wdata,
    output logic [DW-1:0]    d_rdata,
    output logic             h_irq,
    output logic             d_irq,
    output logic             h2d_busy,
    output logic             d2h_busy,
    output logic             h2d_err,
    output logic             d2h_err,
    output logic [CNT_W-1:0] h2d_overrun,
    output logic [CNT_W-1:0] d2h_overrun,
    output logic             collision
);
    import mbox_pkg::*;

    localparam int RAW = $clog2(RAM_WORDS);
    localparam logic [AW-1:0] STAT_LO = AW'(2 * MSG_WORDS);
    localparam logic [AW-1:0] RAM_END = AW'(RAM_WORDS);
    localparam logic [AW-1:0] A_RING  = AW'(RAM_WORDS + REG_RING_OFS);
    localparam logic [AW-1:0] A_ACK   = AW'(RAM_WORDS + REG_ACK_OFS);
    localparam logic [AW-1:0] A_CLR   = AW'(RAM_WORDS + REG_CLR_OFS);

    // per-side views, index 0 = host, 1 = device
    logic [1:0]    en_s, we_s, wr_s, rd_in_ram, tx_req, stat_wr;
    logic [1:0]    ring_req, ack_req, clr_req, tx_ok, ring_evt, ack_evt;
    logic [1:0]    busy_c, err_c;
    logic [AW-1:0] addr_s [2];
    logic [DW-1:0] wd_s   [2];
    logic [CNT_W-1:0] ovr_c [2];
    logic [DW-1:0] ram_rd [2];
    logic          ram_clash;

    assign en_s      = {d_en, h_en};
    assign we_s      = {d_we, h_we};
    assign addr_s[0] = h_addr;
    assign addr_s[1] = d_addr;
    assign wd_s[0]   = h_wdata;
    assign wd_s[1]   = d_wdata;

    for (genvar s = 0; s < 2; s++) begin : g_dec
        localparam logic [AW-1:0] TX_LO = AW'(s * MSG_WORDS);
        localparam logic [AW-1:0] TX_HI = AW'((s + 1) * MSG_WORDS);
        assign wr_s[s]      = en_s[s] && we_s[s];
        assign rd_in_ram[s] = en_s[s] && (addr_s[s] < RAM_END);
        assign tx_req[s]    = wr_s[s] && (addr_s[s] >= TX_LO) && (addr_s[s] < TX_HI);
        assign stat_wr[s]   = wr_s[s] && (addr_s[s] >= STAT_LO) && (addr_s[s] < RAM_END);
        assign ring_req[s]  = wr_s[s] && (addr_s[s] == A_RING);
        assign ack_req[s]   = wr_s[s] && (addr_s[s] == A_ACK);
        assign clr_req[s]   = wr_s[s] && (addr_s[s] == A_CLR);
    end

    // channel c carries messages sent by side c; the peer acknowledges
    for (genvar c = 0; c < 2; c++) begin : g_ch
        mbox_chan #(.SEQ_W(SEQ_W), .CNT_W(CNT_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .tx_req   (tx_req[c]),
            .ring_req (ring_req[c]),
            .ring_seq (wd_s[c][SEQ_W-1:0]),
            .ack_req  (ack_req[1-c]),
            .ack_seq  (wd_s[1-c][SEQ_W-1:0]),
            .clr_req  (clr_req[c]),
            .busy     (busy_c[c]),
            .err      (err_c[c]),
            .overrun  (ovr_c[c]),
            .tx_ok    (tx_ok[c]),
            .ring_evt (ring_evt[c]),
            .ack_evt  (ack_evt[c])
        );
    end

    mbox_ram #(.DW(DW), .WORDS(RAM_WORDS)) u_ram (
        .clk    (clk),
        .rst_n  (rst_n),
        .re_a   (rd_in_ram[SIDE_HOST]),
        .we_a   (tx_ok[SIDE_HOST] || stat_wr[SIDE_HOST]),
        .addr_a (h_addr[RAW-1:0]),
        .wd_a   (h_wdata),
        .rd_a   (ram_rd[0]),
        .re_b   (rd_in_ram[SIDE_DEV]),
        .we_b   (tx_ok[SIDE_DEV] || stat_wr[SIDE_DEV]),
        .addr_b (d_addr[RAW-1:0]),
        .wd_b   (d_wdata),
        .rd_b   (ram_rd[1]),
        .clash  (ram_clash)
    );

    typedef struct packed {
        logic [1:0] irq;
        logic       coll;
        logic [1:0] ctl_rd;
    } top_t;

    top_t top_d, top_q;

    always_comb begin
        top_d = top_q;
        for (int s = 0; s < 2; s++) begin
            top_d.irq[s] = (top_q.irq[s] && !clr_req[s]) || ring_evt[1-s] || ack_evt[s];
            if (en_s[s]) top_d.ctl_rd[s] = !rd_in_ram[s];
        end
        if (ram_clash) top_d.coll = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign h_rdata     = top_q.ctl_rd[0] ? '0 : ram_rd[0];
    assign d_rdata     = top_q.ctl_rd[1] ? '0 : ram_rd[1];
    assign h_irq       = top_q.irq[0];
    assign d_irq       = top_q.irq[1];
    assign collision   = top_q.coll;
    assign h2d_busy    = busy_c[0];
    assign d2h_busy    = busy_c[1];
    assign h2d_err     = err_c[0];
    assign d2h_err     = err_c[1];
    assign h2d_overrun = ovr_c[0];
    assign d2h_overrun = ovr_c[1];
endmodule

// File: rtl/mbox_checker.sv
module mbox_checker #(
    parameter int DW         = 32,
    parameter int MSG_WORDS  = 16,
    parameter int STAT_WORDS = 32,
    parameter int SEQ_W      = 4,
    parameter int CNT_W      = 8,
    localparam int RAM_WORDS = 2 * MSG_WORDS + STAT_WORDS,
    localparam int AW        = $clog2(RAM_WORDS) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             h_en,
    input logic             h_we,
    input logic [AW-1:0]    h_addr,
    input logic [DW-1:0]    h_wdata,
    input logic [DW-1:0]    h_rdata,
    input logic             d_en,
    input logic             d_we,
    input logic [AW-1:0]    d_addr,
    input logic [DW-1:0]    d_wdata,
    input logic [DW-1:0]    d_rdata,
    input logic             h_irq,
    input logic             d_irq,
    input logic             h2d_busy,
    input logic             d2h_busy,
    input logic             h2d_err,
    input logic             d2h_err,
    input logic [CNT_W-1:0] h2d_overrun,
    input logic [CNT_W-1:0] d2h_overrun,
    input logic             collision
);
    localparam logic [AW-1:0] RAM_END = AW'(RAM_WORDS);
    localparam logic [AW-1:0] A_RING  = AW'(RAM_WORDS);
    localparam logic [AW-1:0] A_ACK   = AW'(RAM_WORDS + 1);
    localparam logic [AW-1:0] A_CLR   = AW'(RAM_WORDS + 2);
    localparam logic [AW-1:0] TX_HI   = AW'(MSG_WORDS);

    a_r3_busy_needs_ring: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(h2d_busy) |-> $past(h_en && h_we && h_addr == A_RING));

    a_r5_busy_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(h2d_busy) |-> $past(d_en && d_we && d_addr == A_ACK));

    a_r6_err_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(h2d_err) |-> $past(d_en && d_we && d_addr == A_ACK));

    a_r8_dirq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(d_irq) |-> $past(h_en && h_we && (h_addr == A_RING || h_addr == A_ACK)));

    a_r8_hirq_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(h_irq) |-> $past(h_en && h_we && h_addr == A_CLR));

    a_r7_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (h2d_overrun != $past(h2d_overrun)) |->
            $past(h2d_busy && h_en && h_we && h_addr < TX_HI));

    a_r9_collision_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(collision) |-> $past(h_en && h_we && d_en && d_we && h_addr == d_addr));

    a_r1_ctl_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $past(h_en && h_addr >= RAM_END) |-> (h_rdata == '0));
endmodule

bind mbox_top mbox_checker #(
    .DW(DW), .MSG_WORDS(MSG_WORDS), .STAT_WORDS(STAT_WORDS),
    .SEQ_W(SEQ_W), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/mbox_top_test.sv
`timescale 1ns/1ps
module mbox_top_test;
    logic clk = 0;
    logic rst_n = 0;
    always #5 clk = ~clk;

    logic        b_en [2];
    logic        b_we [2];
    logic [6:0]  b_addr [2];
    logic [31:0] b_wd [2];

    logic [31:0] h_rdata, d_rdata;
    logic h_irq, d_irq, h2d_busy, d2h_busy, h2d_err, d2h_err, collision;
    logic [7:0] h2d_overrun, d2h_overrun;

    mbox_top uut (
        .clk(clk), .rst_n(rst_n),
        .h_en(b_en[0]), .h_we(b_we[0]), .h_addr(b_addr[0]), .h_wdata(b_wd[0]), .h_rdata(h_rdata),
        .d_en(b_en[1]), .d_we(b_we[1]), .d_addr(b_addr[1]), .d_wdata(b_wd[1]), .d_rdata(d_rdata),
        .h_irq(h_irq), .d_irq(d_irq), .h2d_busy(h2d_busy), .d2h_busy(d2h_busy),
        .h2d_err(h2d_err), .d2h_err(d2h_err), .h2d_overrun(h2d_overrun),
        .d2h_overrun(d2h_overrun), .collision(collision)
    );

    int total = 0;
    int bad = 0;
    bit done = 0;

    // ---------------- reference model ----------------
    logic [31:0] m_mem [64];
    logic [31:0] m_rd [2];
    bit m_busy [2], m_err [2], m_irq [2], m_coll;
    int m_seq [2], m_ovr [2];

    always @(posedge clk) begin
        bit wr [2], rg [2], ak [2], cl [2], rgok [2], wen [2];
        logic [31:0] nrd [2];
        bit nbusy [2], nerr [2], nirq [2];
        int nseq [2], novr [2];
        int a;
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) m_mem[i] = 0;
            for (int s = 0; s < 2; s++) begin
                m_rd[s] = 0; m_busy[s] = 0; m_err[s] = 0; m_irq[s] = 0;
                m_seq[s] = 0; m_ovr[s] = 0;
            end
            m_coll = 0;
        end else begin
            for (int s = 0; s < 2; s++) begin
                a = int'(b_addr[s]);
                wr[s] = b_en[s] && b_we[s];
                rg[s] = wr[s] && a == 64;
                ak[s] = wr[s] && a == 65;
                cl[s] = wr[s] && a == 66;
                nrd[s] = m_rd[s];
                if (b_en[s]) nrd[s] = (a < 64) ? m_mem[a] : 32'd0;
                nbusy[s] = m_busy[s]; nerr[s] = m_err[s]; nseq[s] = m_seq[s]; novr[s] = m_ovr[s];
                wen[s] = 0;
                if (wr[s] && a >= 16 * s && a < 16 * s + 16) begin
                    if (m_busy[s]) begin if (novr[s] < 255) novr[s]++; end
                    else wen[s] = 1;
                end
                if (wr[s] && a >= 32 && a < 64) wen[s] = 1;
                rgok[s] = rg[s] && !m_busy[s];
            end
            for (int c = 0; c < 2; c++) begin
                if (cl[c]) nerr[c] = 0;
                if (rgok[c]) begin nbusy[c] = 1; nseq[c] = int'(b_wd[c][3:0]); end
                if (ak[1-c]) begin
                    if (m_busy[c] && int'(b_wd[1-c][3:0]) == m_seq[c]) nbusy[c] = 0;
                    else nerr[c] = 1;
                end
            end
            for (int s = 0; s < 2; s++)
                nirq[s] = (m_irq[s] && !cl[s]) || rgok[1-s] || ak[1-s];
            if (wen[0] && wen[1] && b_addr[0] == b_addr[1]) m_coll = 1;
            if (wen[1]) m_mem[b_addr[1]] = b_wd[1];
            if (wen[0]) m_mem[b_addr[0]] = b_wd[0];
            for (int s = 0; s < 2; s++) begin
                m_rd[s] = nrd[s]; m_busy[s] = nbusy[s]; m_err[s] = nerr[s];
                m_irq[s] = nirq[s]; m_seq[s] = nseq[s]; m_ovr[s] = novr[s];
            end
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // compare with the model on every clock, away from the active edge
    always @(negedge clk) if (rst_n && !done) begin
        chk(h_rdata == m_rd[0], "R1 h_rdata", h_rdata, m_rd[0]);
        chk(d_rdata == m_rd[1], "R1 d_rdata", d_rdata, m_rd[1]);
        chk(h2d_busy == m_busy[0], "R3 h2d_busy", h2d_busy, m_busy[0]);
        chk(d2h_busy == m_busy[1], "R3 d2h_busy", d2h_busy, m_busy[1]);
        chk(h2d_err == m_err[0], "R6 h2d_err", h2d_err, m_err[0]);
        chk(d2h_err == m_err[1], "R6 d2h_err", d2h_err, m_err[1]);
        chk(int'(h2d_overrun) == m_ovr[0], "R7 h2d_overrun", h2d_overrun, m_ovr[0]);
        chk(int'(d2h_overrun) == m_ovr[1], "R7 d2h_overrun", d2h_overrun, m_ovr[1]);
        chk(h_irq == m_irq[0], "R8 h_irq", h_irq, m_irq[0]);
        chk(d_irq == m_irq[1], "R8 d_irq", d_irq, m_irq[1]);
        chk(collision == m_coll, "R9 collision", collision, m_coll);
    end

    task automatic idle();
        for (int s = 0; s < 2; s++) begin b_en[s] = 0; b_we[s] = 0; b_addr[s] = 0; b_wd[s] = 0; end
    endtask

    // one cycle: both ports driven, then sampled 1 ns after the edge
    task automatic op2(input bit he, input bit hw, input int ha, input int hd,
                       input bit de, input bit dw, input int da, input int dd);
        @(negedge clk);
        b_en[0] = he; b_we[0] = hw; b_addr[0] = 7'(ha); b_wd[0] = hd;
        b_en[1] = de; b_we[1] = dw; b_addr[1] = 7'(da); b_wd[1] = dd;
        @(posedge clk); #1;
        idle();
    endtask
    task automatic hw(input int a, input int d); op2(1,1,a,d,0,0,0,0); endtask
    task automatic dw(input int a, input int d); op2(0,0,0,0,1,1,a,d); endtask
    task automatic hr(input int a); op2(1,0,a,0,0,0,0,0); endtask
    task automatic dr(input int a); op2(0,0,0,0,1,0,a,0); endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        #1;
        // R11 reset state
        chk(h2d_busy == 0 && d2h_busy == 0 && h_irq == 0 && d_irq == 0, "R11 flags", h2d_busy, 0);
        chk(h_rdata == 0 && d_rdata == 0 && collision == 0, "R11 rdata", h_rdata, 0);
        dr(40);
        chk(d_rdata == 0, "R11 memory zero", d_rdata, 0);

        // host fills its send area, device reads it (R1)
        for (int i = 0; i < 13; i++) hw(i, 32'h100 + i);
        dr(7);
        chk(d_rdata == 32'h107, "R1 device reads host word", d_rdata, 32'h107);
        hr(66);
        chk(h_rdata == 0, "R1 control read zero", h_rdata, 0);

        // ring (R3)
        hw(64, 5);
        chk(h2d_busy == 1 && d_irq == 1, "R3 ring sets busy and d_irq", h2d_busy, 1);
        // R4 second ring ignored
        dw(66, 0);
        chk(d_irq == 0, "R8 device clear", d_irq, 0);
        hw(64, 9);
        chk(d_irq == 0 && h2d_busy == 1, "R4 ring while busy", d_irq, 0);
        // R7 blocked write
        hw(7, 32'hDEAD);
        chk(h2d_overrun == 1, "R7 overrun count", h2d_overrun, 1);
        dr(7);
        chk(d_rdata == 32'h107, "R7 word kept", d_rdata, 32'h107);
        // R10 status writes while busy
        hw(33, 32'hAAAA); dw(34, 32'hBBBB);
        hr(34);
        chk(h_rdata == 32'hBBBB, "R10 status write during busy", h_rdata, 32'hBBBB);
        // R6 mismatched ack (device acknowledges seq 3, pending 5)
        dw(65, 3);
        chk(h2d_err == 1 && h2d_busy == 1 && h_irq == 1, "R6 mismatch keeps busy", h2d_busy, 1);
        hw(66, 0);
        chk(h_irq == 0 && h2d_err == 0, "R8 host clear resets irq and err", h2d_err, 0);
        // R5 matching ack
        dw(65, 5);
        chk(h2d_busy == 0 && h_irq == 1, "R5 matching ack", h2d_busy, 0);
        hw(66, 0);
        // R2 writes into peer area ignored
        dw(3, 32'h55); hw(20, 32'h66);
        hr(3);
        chk(h_rdata == 32'h103, "R2 device into host area", h_rdata, 32'h103);
        dr(20);
        chk(d_rdata == 0, "R2 host into device area", d_rdata, 0);
        // device-to-host direction
        dw(20, 32'h777); dw(64, 9);
        chk(d2h_busy == 1 && h_irq == 1, "R3 device ring", d2h_busy, 1);
        hr(20);
        chk(h_rdata == 32'h777, "R1 host reads device word", h_rdata, 32'h777);
        op2(1,1,65,9,0,0,0,0);
        chk(d2h_busy == 0 && d_irq == 1, "R5 host acknowledges", d2h_busy, 0);
        // R8 clear with simultaneous set: set wins
        op2(1,1,64,2,1,1,66,0);
        chk(d_irq == 1, "R8 set wins over clear", d_irq, 1);
        // R6 ack while idle on d2h
        hw(65, 1);
        chk(d2h_err == 1 && d2h_busy == 0, "R6 idle ack", d2h_err, 1);
        dw(65, 2);
        chk(h2d_busy == 0, "R5 ack seq 2", h2d_busy, 0);
        // R9 collision
        op2(1,1,45,32'h1111,1,1,45,32'h2222);
        chk(collision == 1, "R9 collision flag", collision, 1);
        dr(45);
        chk(d_rdata == 32'h1111, "R9 host wins", d_rdata, 32'h1111);
        // R7 saturation
        hw(64, 4);
        for (int i = 0; i < 260; i++) hw(i % 16, i);
        chk(h2d_overrun == 255, "R7 saturation", h2d_overrun, 255);
        dw(65, 4);

        // mixed random phase, checked by the model every cycle
        for (int k = 0; k < 4000; k++) begin
            int ha, da, hd, dd;
            ha = ($urandom_range(0, 3) == 0) ? $urandom_range(64, 68) : $urandom_range(0, 63);
            da = ($urandom_range(0, 3) == 0) ? $urandom_range(64, 68) : $urandom_range(0, 63);
            hd = $urandom; dd = $urandom;
            if (da == 65 && $urandom_range(0, 1)) dd = m_seq[0];
            if (ha == 65 && $urandom_range(0, 1)) hd = m_seq[1];
            if ($urandom_range(0, 7) == 0) da = ha;
            op2($urandom_range(0, 1), $urandom_range(0, 1), ha, hd,
                $urandom_range(0, 1), $urandom_range(0, 1), da, dd);
        end

        @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule